// File: doc/BRIEF.md
# One-of-Four Handshake Link Transmitter

This block takes typed flits from a clocked producer and places them on a delay-insensitive style link. Each flit is written across a group of symbol positions. Every position carries one 2-bit digit as a 1-of-4 code on four rails. A whole flit is one symbol on the link, and it is closed by a four-phase return-to-zero handshake on a single acknowledge wire. A header flit uses its first four positions for a 4-bit X and a 4-bit Y destination. A tail flit is followed by an end-of-frame token on a wire of its own, and that token has its own complete handshake.

The producer offers a flit with a valid/ready pair. The transmitter holds ready low until every phase of that flit's handshake has finished. The acknowledge comes from the link side, so it passes through a two-stage synchronizer before the control logic acts on it. Every reaction to an acknowledge edge therefore lands a fixed number of clock edges later.

Top module: `q4_link_tx`

## Requirements
- R1: Out of reset every rail and the end-of-frame wire are low and `flit_ready` is high.
- R2: While a flit is on the link, each symbol position has exactly one rail high. Digit v at position p is shown as `lnk_rail[v][p]` high.
- R3: For a data flit (kind code 0) or a tail flit (kind code 2), position p carries `flit_data[2p+1:2p]`. The least significant bit pair goes to position 0.
- R4: For a header flit (kind code 1), the positions carry the following, and data bits above `FLIT_W-9` are not sent:
  - position 0: `flit_dx[1:0]`
  - position 1: `flit_dx[3:2]`
  - position 2: `flit_dy[1:0]`
  - position 3: `flit_dy[3:2]`
  - position 4+k: `flit_data[2k+1:2k]`
- R5: `flit_ready` is high only when the transmitter is idle. A flit is taken on a rising edge where valid and ready are both high. Its code appears on the rails right after that edge.
- R6: The rails hold their code unchanged until the acknowledge is seen high. They all return to zero on the third rising edge after the acknowledge rises.
- R7: After the return to zero, the transmitter waits for the acknowledge to fall. For a non-tail flit, `flit_ready` returns on the third rising edge after the fall.
- R8: For a tail flit, `lnk_eof` rises on the third edge after the data acknowledge falls, with the rails still zero. It drops on the third edge after the acknowledge rises again. `flit_ready` returns on the third edge after the acknowledge falls again.
- R9: `lnk_eof` and any rail are never high together. An acknowledge pulse while idle leaves the rails, `lnk_eof` and `flit_ready` unchanged.
- R10: Kind code 3 is sent as a data flit, with no end-of-frame token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_valid | input | 1 | Producer offers a flit |
| flit_ready | output | 1 | Transmitter idle and able to take a flit |
| flit_kind | input | 2 | 0 data, 1 header, 2 tail, 3 treated as data |
| flit_dx | input | 4 | X destination, used by header flits |
| flit_dy | input | 4 | Y destination, used by header flits |
| flit_data | input | FLIT_W | Flit payload |
| lnk_rail | output | 4 x FLIT_W/2 | Rail v of every symbol position, indexed [v][position] |
| lnk_eof | output | 1 | End-of-frame token wire |
| lnk_ack | input | 1 | Acknowledge from the link receiver |

## Verification
Two things can meet in a single cycle. One is the close of a tail flit's data handshake, when the acknowledge fall is finally seen. The other is the launch of the end-of-frame token. A wrong design could raise `lnk_eof` while the rails still hold data, or raise it a cycle early. The bench drives the acknowledge at falling clock edges and samples the rails, `lnk_eof` and `flit_ready` after each of the three following rising edges. It expects the token to appear exactly on the third edge, with all rails already zero. A second pairing is a spurious acknowledge pulse while idle against the next accepted flit. The bench judges it by the rails staying zero and ready staying high, and then by a clean handshake on the flit that follows.

// File: rtl/q4_link_pkg.sv
package q4_link_pkg;

    localparam int RAILS     = 4;
    localparam int ADDR_SYMS = 4;
    localparam int COORD_W   = 4;

    typedef enum logic [1:0] {
        KIND_DATA  = 2'd0,
        KIND_HEAD  = 2'd1,
        KIND_TAIL  = 2'd2,
        KIND_SPARE = 2'd3
    } flit_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_WAIT_ACK_HI,
        ST_RTZ,
        ST_WAIT_ACK_LO,
        ST_EOF_DRIVE,
        ST_EOF_WAIT_HI,
        ST_EOF_RTZ,
        ST_EOF_WAIT_LO
    } tx_state_e;

    // what the link outputs show in a given state
    typedef struct packed {
        logic data_on;
        logic eof_on;
        logic idle;
    } drive_t;

    function automatic logic [RAILS-1:0] dig_to_rails(input logic [1:0] v);
        return 4'b0001 << v;
    endfunction

    function automatic drive_t state_drive(input tx_state_e s);
        drive_t d;
        d.data_on = (s == ST_DRIVE) || (s == ST_WAIT_ACK_HI);
        d.eof_on  = (s == ST_EOF_DRIVE) || (s == ST_EOF_WAIT_HI);
        d.idle    = (s == ST_IDLE);
        return d;
    endfunction

endpackage

// File: rtl/q4_ack_sync.sv
module q4_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_async,
    output logic ack_sync
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], ack_async};
    end

    assign ack_sync = sh_q[STAGES-1];
endmodule

// File: rtl/q4_sym_encoder.sv
module q4_sym_encoder
    import q4_link_pkg::*;
#(
    parameter int FLIT_W = 16,
    localparam int SYM_N = FLIT_W / 2
) (
    input  flit_kind_e                     kind,
    input  logic [COORD_W-1:0]             dx,
    input  logic [COORD_W-1:0]             dy,
    input  logic [FLIT_W-1:0]              data,
    output logic [RAILS-1:0][SYM_N-1:0]    code
);
    logic [2*COORD_W-1:0]       addr;
    logic [SYM_N-1:0][1:0]      head_dig;
    logic [SYM_N-1:0][1:0]      body_dig;
    logic                       is_head;

    assign addr    = {dy, dx};
    assign is_head = (kind == KIND_HEAD);

    for (genvar p = 0; p < SYM_N; p++) begin : g_pos
        if (p < ADDR_SYMS) begin : g_addr
            assign head_dig[p] = addr[2*p +: 2];
        end else begin : g_pay
            assign head_dig[p] = data[2*(p-ADDR_SYMS) +: 2];
        end
        assign body_dig[p] = data[2*p +: 2];
    end

    always_comb begin
        code = '0;
        for (int p = 0; p < SYM_N; p++) begin
            logic [RAILS-1:0] oh;
            oh = dig_to_rails(is_head ? head_dig[p] : body_dig[p]);
            for (int r = 0; r < RAILS; r++) code[r][p] = oh[r];
        end
    end
endmodule

// File: rtl/q4_link_tx.sv
module q4_link_tx
    import q4_link_pkg::*;
#(
    parameter int FLIT_W      = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SYM_N      = FLIT_W / 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flit_valid,
    output logic                        flit_ready,
    input  logic [1:0]                  flit_kind,
    input  logic [COORD_W-1:0]          flit_dx,
    input  logic [COORD_W-1:0]          flit_dy,
    input  logic [FLIT_W-1:0]           flit_data,
    output logic [RAILS-1:0][SYM_N-1:0] lnk_rail,
    output logic                        lnk_eof,
    input  logic                        lnk_ack
);
    tx_state_e                  state_q, state_d;
    logic [RAILS-1:0][SYM_N-1:0] code_q, enc_code;
    logic                       tail_q;
    logic                       ack_s;
    logic                       take;
    drive_t                     drv;

    q4_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ack_async (lnk_ack),
        .ack_sync  (ack_s)
    );

    q4_sym_encoder #(.FLIT_W(FLIT_W)) u_enc (
        .kind (flit_kind_e'(flit_kind)),
        .dx   (flit_dx),
        .dy   (flit_dy),
        .data (flit_data),
        .code (enc_code)
    );

    assign drv        = state_drive(state_q);
    assign flit_ready = drv.idle;
    assign take       = flit_valid && drv.idle;
    assign lnk_rail   = drv.data_on ? code_q : '0;
    assign lnk_eof    = drv.eof_on;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (take)   state_d = ST_DRIVE;
            ST_DRIVE:                   state_d = ST_WAIT_ACK_HI;
            ST_WAIT_ACK_HI: if (ack_s)  state_d = ST_RTZ;
            ST_RTZ:                     state_d = ST_WAIT_ACK_LO;
            ST_WAIT_ACK_LO: if (!ack_s) state_d = tail_q ? ST_EOF_DRIVE : ST_IDLE;
            ST_EOF_DRIVE:               state_d = ST_EOF_WAIT_HI;
            ST_EOF_WAIT_HI: if (ack_s)  state_d = ST_EOF_RTZ;
            ST_EOF_RTZ:                 state_d = ST_EOF_WAIT_LO;
            ST_EOF_WAIT_LO: if (!ack_s) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            tail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                code_q <= enc_code;
                tail_q <= (flit_kind_e'(flit_kind) == KIND_TAIL);
            end
        end
    end
endmodule

// File: rtl/q4_link_tx_chk.sv
module q4_link_tx_chk
    import q4_link_pkg::*;
#(
    parameter int FLIT_W = 16,
    localparam int SYM_N = FLIT_W / 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        flit_valid,
    input logic                        flit_ready,
    input logic [RAILS-1:0][SYM_N-1:0] lnk_rail,
    input logic                        lnk_eof,
    input logic                        lnk_ack
);
    logic rails_on;
    assign rails_on = |lnk_rail;

    // R1: reset leaves the link quiet and the input open
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!(|lnk_rail) && !lnk_eof && flit_ready))
        else $error("p_reset_quiet_r1");

    // R2: one rail per position while driving
    for (genvar p = 0; p < SYM_N; p++) begin : g_oh
        p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
            rails_on |-> $onehot({lnk_rail[3][p], lnk_rail[2][p],
                                  lnk_rail[1][p], lnk_rail[0][p]}))
            else $error("p_onehot_r2 position %0d", p);
    end

    // R5: busy link means closed input
    p_busy_not_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (rails_on || lnk_eof) |-> !flit_ready)
        else $error("p_busy_not_ready_r5");

    // R5: an accepted flit shows on the rails next cycle
    p_accept_drives_r5: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && flit_ready) |=> rails_on)
        else $error("p_accept_drives_r5");

    // R6: code does not change while held
    p_code_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (rails_on && $past(rails_on)) |-> $stable(lnk_rail))
        else $error("p_code_stable_r6");

    // R9: token and data never together
    p_eof_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(rails_on && lnk_eof))
        else $error("p_eof_excl_r9");
endmodule

bind q4_link_tx q4_link_tx_chk #(.FLIT_W(FLIT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flit_valid (flit_valid),
    .flit_ready (flit_ready),
    .lnk_rail   (lnk_rail),
    .lnk_eof    (lnk_eof),
    .lnk_ack    (lnk_ack)
);

// File: tb/q4_link_tx_test.sv
`timescale 1ns/1ps
module q4_link_tx_test;
    localparam int FLIT_W = 16;
    localparam int SYM_N  = FLIT_W / 2;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    flit_valid = 1'b0;
    logic                    flit_ready;
    logic [1:0]              flit_kind = 2'd0;
    logic [3:0]              flit_dx = 4'd0;
    logic [3:0]              flit_dy = 4'd0;
    logic [FLIT_W-1:0]       flit_data = '0;
    logic [3:0][SYM_N-1:0]   lnk_rail;
    logic                    lnk_eof;
    logic                    lnk_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    q4_link_tx #(.FLIT_W(FLIT_W)) uut (
        .clk(clk), .rst(rst), .flit_valid(flit_valid), .flit_ready(flit_ready),
        .flit_kind(flit_kind), .flit_dx(flit_dx), .flit_dy(flit_dy),
        .flit_data(flit_data), .lnk_rail(lnk_rail), .lnk_eof(lnk_eof),
        .lnk_ack(lnk_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0][SYM_N-1:0] exp_code(
        input logic [1:0] kind, input logic [3:0] dx, input logic [3:0] dy,
        input logic [FLIT_W-1:0] data);
        logic [3:0][SYM_N-1:0] r;
        r = '0;
        for (int p = 0; p < SYM_N; p++) begin
            logic [1:0] v;
            if (kind == 2'd1) begin
                case (p)
                    0: v = dx[1:0];
                    1: v = dx[3:2];
                    2: v = dy[1:0];
                    3: v = dy[3:2];
                    default: v = data[2*(p-4) +: 2];
                endcase
            end else begin
                v = data[2*p +: 2];
            end
            r[v][p] = 1'b1;
        end
        return r;
    endfunction

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_onehot(input string req);
        bit ok;
        ok = 1'b1;
        for (int p = 0; p < SYM_N; p++)
            if ((lnk_rail[0][p] + lnk_rail[1][p] + lnk_rail[2][p] + lnk_rail[3][p]) != 1)
                ok = 1'b0;
        chk(ok, req, "one rail per position", lnk_rail, 0);
    endtask

    // full data-symbol handshake, starting at the negedge after acceptance
    task automatic data_phase(input logic [3:0][SYM_N-1:0] exp, input bit tail,
                              input string req);
        chk(lnk_rail == exp, req, "rails after accept", lnk_rail, exp);
        check_onehot("R2");
        chk(!flit_ready, "R5", "ready while driving", flit_ready, 0);
        tick; tick;
        chk(lnk_rail == exp, "R6", "rails held without ack", lnk_rail, exp);
        lnk_ack = 1'b1;
        tick;
        chk(lnk_rail == exp, "R6", "rails held edge 1", lnk_rail, exp);
        tick;
        chk(lnk_rail == exp, "R6", "rails held edge 2", lnk_rail, exp);
        tick;
        chk(lnk_rail == '0, "R6", "rails zero edge 3", lnk_rail, 0);
        tick;
        chk(!flit_ready && lnk_rail == '0, "R7", "waiting for ack low",
            {flit_ready, lnk_rail}, 0);
        lnk_ack = 1'b0;
        tick;
        chk(!flit_ready && !lnk_eof, "R7", "edge 1 after fall", {flit_ready, lnk_eof}, 0);
        tick;
        chk(!flit_ready && !lnk_eof, "R7", "edge 2 after fall", {flit_ready, lnk_eof}, 0);
        tick;
        if (tail) begin
            chk(lnk_eof && lnk_rail == '0, "R8", "eof on edge 3", {lnk_eof, lnk_rail},
                {1'b1, 32'h0});
            chk(!flit_ready, "R8", "ready during eof", flit_ready, 0);
        end else begin
            chk(flit_ready && !lnk_eof, "R7", "ready on edge 3", {flit_ready, lnk_eof}, 2'b10);
        end
    endtask

    task automatic eof_phase;
        tick;
        chk(lnk_eof && lnk_rail == '0, "R8", "eof held without ack",
            {lnk_eof, lnk_rail}, {1'b1, 32'h0});
        lnk_ack = 1'b1;
        tick;
        chk(lnk_eof, "R8", "eof edge 1", lnk_eof, 1);
        tick;
        chk(lnk_eof, "R8", "eof edge 2", lnk_eof, 1);
        tick;
        chk(!lnk_eof, "R8", "eof dropped edge 3", lnk_eof, 0);
        lnk_ack = 1'b0;
        tick;
        tick;
        chk(!flit_ready, "R8", "ready before token done", flit_ready, 0);
        tick;
        chk(flit_ready && !lnk_eof && lnk_rail == '0, "R8", "idle after token",
            {flit_ready, lnk_eof, lnk_rail}, {2'b10, 32'h0});
    endtask

    task automatic send(input logic [1:0] kind, input logic [3:0] dx,
                        input logic [3:0] dy, input logic [FLIT_W-1:0] data,
                        input string req);
        chk(flit_ready, "R5", "ready before offer", flit_ready, 1);
        flit_kind = kind; flit_dx = dx; flit_dy = dy; flit_data = data;
        flit_valid = 1'b1;
        tick;
        flit_valid = 1'b0;
        flit_data  = ~data;
        data_phase(exp_code(kind, dx, dy, data), kind == 2'd2, req);
        if (kind == 2'd2) eof_phase;
    endtask

    task automatic test_reset;
        rst = 1'b1;
        tick; tick;
        rst = 1'b0;
        tick;
        chk(lnk_rail == '0 && !lnk_eof && flit_ready, "R1", "reset state",
            {flit_ready, lnk_eof, lnk_rail}, {2'b10, 32'h0});
    endtask

    task automatic test_data;   // R3
        send(2'd0, 4'h0, 4'h0, 16'hE41B, "R3");
        send(2'd0, 4'h0, 4'h0, 16'h0000, "R3");
    endtask

    task automatic test_header; // R4
        send(2'd1, 4'hA, 4'h5, 16'hFFC6, "R4");
        send(2'd1, 4'h0, 4'hF, 16'h0039, "R4");
    endtask

    task automatic test_tail;   // R8
        send(2'd2, 4'h0, 4'h0, 16'h93C6, "R8");
    endtask

    task automatic test_spare;  // R10
        send(2'd3, 4'h0, 4'h0, 16'hFFFF, "R10");
        tick;
        chk(!lnk_eof && flit_ready, "R10", "no token after kind 3",
            {lnk_eof, flit_ready}, 2'b01);
    endtask

    task automatic test_idle_ack; // R9
        lnk_ack = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick;
            chk(lnk_rail == '0 && !lnk_eof && flit_ready, "R9", "ack in idle ignored",
                {flit_ready, lnk_eof, lnk_rail}, {2'b10, 32'h0});
        end
        lnk_ack = 1'b0;
        tick; tick; tick;
        send(2'd0, 4'h0, 4'h0, 16'h5A3C, "R9");
    endtask

    task automatic test_held_valid; // R5
        flit_kind = 2'd0; flit_data = 16'h1234; flit_valid = 1'b1;
        tick;
        flit_data = 16'hABCD;
        chk(lnk_rail == exp_code(2'd0, 4'h0, 4'h0, 16'h1234), "R5",
            "first flit latched", lnk_rail, exp_code(2'd0, 4'h0, 4'h0, 16'h1234));
        tick;
        chk(lnk_rail == exp_code(2'd0, 4'h0, 4'h0, 16'h1234), "R5",
            "busy ignores held valid", lnk_rail, exp_code(2'd0, 4'h0, 4'h0, 16'h1234));
        flit_valid = 1'b0;
        lnk_ack = 1'b1; tick; tick; tick;
        lnk_ack = 1'b0; tick; tick; tick;
        chk(flit_ready, "R5", "ready after held-valid flit", flit_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset;
        test_data;
        test_header;
        test_tail;
        test_spare;
        test_idle_ack;
        test_held_valid;
        tick;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule